// File: doc/BRIEF.md
# Seven-to-one display link serializer

This block turns a 28-bit parallel pixel word (24 colour bits plus 4 control bits) into four serial data lanes and one forwarded clock lane. Everything runs on a bit clock at seven times the pixel rate, with a one-cycle frame strobe that marks the first bit slot of each pixel period. The pixel clock comes in as a plain signal. The block samples it on the bit clock and detects its edges. The parallel word is captured on the pixel-clock edge picked by the edge-select pin: rising when the pin is high, falling when it is low.

The captured word is double-buffered. It passes to the per-lane shift registers only at the frame strobe, so each lane sends seven bits of one word per pixel period and never a mix of two words. The clock lane repeats a fixed seven-bit pattern so that a receiver can find word boundaries.

Holding the active-low power-down pin low drops the output enable, which stands in for a tri-state driver, and holds every serial output at zero. The link has no flow control. A new word is taken on every pixel period, and there is no valid/ready handshake or back-pressure at either edge. The fast clock source, the differential drivers and the analog levels are outside this block.

Top module: `ser7_link_tx`

## Requirements
- R1: Every pixel period, which is seven bit-clock cycles between frame strobes, all 28 word bits are sent: 7 bits on each of the 4 data lanes.
- R2: Lane k carries word bits 7k to 7k+6, and the lowest index of each group is sent first.
- R3: When the edge-select input is 1, the word present at the rising pixel-clock edge is the one captured.
- R4: When the edge-select input is 0, the word present at the falling pixel-clock edge is captured. An unconnected pin, pulled low outside the block, therefore selects falling-edge capture.
- R5: While power-down is low, the output enable is 0 and all lane outputs and the clock-lane output are 0 from the next bit-clock edge onward. Normal output returns on the edge after power-down goes high again.
- R6: Bit 0 of each lane is output in the bit slot that begins at the bit-clock edge where the frame strobe is sampled high. Bits 1 to 6 follow in order, one per bit-clock cycle.
- R7: In every pixel period the clock lane outputs bits 0 to 6 as 1,1,0,0,0,1,1.
- R8: The word sent in a pixel period is the last word captured before that period's frame strobe. Changes on the parallel input during a period do not affect the lanes until the next strobe.
- R9: During reset and until the first frame strobe after reset, every lane output and the clock-lane output are 0. During reset the output enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock, seven times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_clk | input | 1 | Pixel clock, sampled on bit_clk |
| frame_strobe | input | 1 | High for one bit_clk cycle at the start of each pixel period |
| rise_sel | input | 1 | 1 = capture on rising pixel-clock edge, 0 = falling |
| pd_n | input | 1 | Active-low power-down |
| pix_word | input | 28 | Parallel pixel word |
| lane_out | output | 4 | Serial data lanes |
| clk_lane_out | output | 1 | Forwarded clock lane |
| drive_en | output | 1 | Output enable standing in for tri-state control |

## Verification
The assertions assume a frame strobe exactly every seven bit-clock cycles once the first strobe has been seen. They also assume the pixel clock stays high and low for at least one bit-clock cycle each, so both of its edges can be detected. The bench derives the pixel clock, the strobe and the data from one phase counter, with the rising pixel-clock edge in the strobe slot. It changes edge select and power-down only at the start of a period. It releases reset while the pixel clock is low, so no false edge is seen.

// File: rtl/ser7_pkg.sv
package ser7_pkg;
  localparam int LANES_DEF = 4;
  localparam int BITS_DEF  = 7;
  localparam logic [BITS_DEF-1:0] CLK_PAT_DEF = 7'b1100011;
endpackage

// File: rtl/ser7_capture.sv
module ser7_capture #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pclk,
  input  logic         edge_rise,
  input  logic [W-1:0] din,
  output logic [W-1:0] word
);
  logic pclk_q;
  logic rise_hit, fall_hit, take;

  assign rise_hit = pclk & ~pclk_q;
  assign fall_hit = ~pclk & pclk_q;
  assign take     = edge_rise ? rise_hit : fall_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pclk_q <= 1'b0;
      word   <= '0;
    end else begin
      pclk_q <= pclk;
      if (take) word <= din;
    end
  end

  AST_RISE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_rise && pclk && !pclk_q) |=> (word == $past(din))); // R3
  AST_FALL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_rise && !pclk && pclk_q) |=> (word == $past(din))); // R4
  AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (pclk == pclk_q) |=> $stable(word)); // R8
endmodule

// File: rtl/ser7_lane.sv
module ser7_lane #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] par,
  output logic         ser
);
  logic [W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sh <= '0;
    else if (load) sh <= par;
    else           sh <= sh >> 1;
  end

  assign ser = sh[0];

  AST_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ser == $past(par[0]))); // R6
  AST_SHIFT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (sh == ($past(sh) >> 1))); // R2
endmodule

// File: rtl/ser7_drive.sv
module ser7_drive #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pd_n,
  input  logic [N-1:0] lane_in,
  input  logic         clk_in,
  output logic [N-1:0] lane_out,
  output logic         clk_out,
  output logic         oe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe <= 1'b0;
    else        oe <= pd_n;
  end

  assign lane_out = oe ? lane_in : '0;
  assign clk_out  = oe & clk_in;

  AST_PD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> (!oe && lane_out == '0 && !clk_out)); // R5
  AST_PD_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    pd_n |=> oe); // R5
endmodule

// File: rtl/ser7_link_tx.sv
module ser7_link_tx
  import ser7_pkg::*;
#(
  parameter int LANES = LANES_DEF,
  parameter int BITS  = BITS_DEF,
  parameter logic [BITS-1:0] CLK_PAT = CLK_PAT_DEF
) (
  input  logic                  bit_clk,
  input  logic                  rst_n,
  input  logic                  pix_clk,
  input  logic                  frame_strobe,
  input  logic                  rise_sel,
  input  logic                  pd_n,
  input  logic [LANES*BITS-1:0] pix_word,
  output logic [LANES-1:0]      lane_out,
  output logic                  clk_lane_out,
  output logic                  drive_en
);
  localparam int WORD = LANES * BITS;
  localparam int CW   = $clog2(BITS) + 1;

  logic [WORD-1:0]  held;
  logic [LANES-1:0] lane_raw;
  logic             clk_raw;

  ser7_capture #(.W(WORD)) i_cap (
    .clk(bit_clk), .rst_n(rst_n), .pclk(pix_clk),
    .edge_rise(rise_sel), .din(pix_word), .word(held)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    ser7_lane #(.W(BITS)) i_lane (
      .clk(bit_clk), .rst_n(rst_n), .load(frame_strobe),
      .par(held[k*BITS +: BITS]), .ser(lane_raw[k])
    );
  end

  ser7_lane #(.W(BITS)) i_clk_lane (
    .clk(bit_clk), .rst_n(rst_n), .load(frame_strobe),
    .par(CLK_PAT), .ser(clk_raw)
  );

  ser7_drive #(.N(LANES)) i_drv (
    .clk(bit_clk), .rst_n(rst_n), .pd_n(pd_n),
    .lane_in(lane_raw), .clk_in(clk_raw),
    .lane_out(lane_out), .clk_out(clk_lane_out), .oe(drive_en)
  );

  // spacing watch for the strobe input
  logic [CW-1:0] since_strobe;
  logic          strobe_seen;

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      since_strobe <= '0;
      strobe_seen  <= 1'b0;
    end else if (frame_strobe) begin
      since_strobe <= '0;
      strobe_seen  <= 1'b1;
    end else if (since_strobe != {CW{1'b1}}) begin
      since_strobe <= since_strobe + 1'b1;
    end
  end

  AST_STROBE_SPACING: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (frame_strobe && strobe_seen) |-> (since_strobe == CW'(BITS-1))); // R1
  AST_CLK_LANE_HEAD: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (frame_strobe && pd_n) |=> (clk_lane_out == CLK_PAT[0])); // R7
  AST_IDLE_BEFORE_STROBE: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (!strobe_seen && !frame_strobe) |=> (lane_out == '0 && !clk_lane_out)); // R9
endmodule

// File: tb/test_ser7_link_tx.sv
module test_ser7_link_tx;
  localparam int LANES = 4;
  localparam int BITS  = 7;
  localparam int WORD  = LANES * BITS;
  localparam logic [6:0] PAT = 7'b1100011;

  logic bit_clk = 1'b0;
  always #4 bit_clk = ~bit_clk;

  logic             rst_n, pix_clk, frame_strobe, rise_sel, pd_n;
  logic [WORD-1:0]  pix_word;
  logic [LANES-1:0] lane_out;
  logic             clk_lane_out, drive_en;

  ser7_link_tx i_ser7_link_tx (
    .bit_clk(bit_clk), .rst_n(rst_n), .pix_clk(pix_clk),
    .frame_strobe(frame_strobe), .rise_sel(rise_sel), .pd_n(pd_n),
    .pix_word(pix_word), .lane_out(lane_out),
    .clk_lane_out(clk_lane_out), .drive_en(drive_en)
  );

  int nchk = 0, nfail = 0;
  int phase = 6;
  logic [WORD-1:0] captured = '0, frame = '0;
  bit loaded = 0;
  string tag = "R9";

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    nchk++;
    if (act !== exp_v) begin
      nfail++;
      $display("FAIL %s phase %0d: actual %0h expected %0h", req, phase, act, exp_v);
    end
  endtask

  task automatic check_outputs();
    logic en;
    logic [LANES-1:0] exp_l;
    logic exp_c;
    en = rst_n ? pd_n : 1'b0;
    for (int k = 0; k < LANES; k++)
      exp_l[k] = en & loaded & frame[k*BITS + phase];
    exp_c = en & loaded & PAT[phase];
    chk({tag, "/R1/R2/R6 data lanes"}, 32'(lane_out), 32'(exp_l));
    chk({tag, "/R7 clock lane"}, 32'(clk_lane_out), 32'(exp_c));
    chk({tag, "/R5 drive enable"}, 32'(drive_en), 32'(en));
  endtask

  task automatic step(input logic [WORD-1:0] w, input logic s, input logic p);
    @(negedge bit_clk);
    check_outputs();
    phase = (phase + 1) % BITS;
    pix_clk = (phase < 4);
    frame_strobe = (phase == 0);
    pix_word = w;
    if (phase == 0) begin
      rise_sel = s;
      pd_n = p;
    end
    if (rst_n) begin
      if (phase == 0) begin
        frame = captured;
        loaded = 1;
        if (rise_sel) captured = w;
      end else if (phase == 4 && !rise_sel) begin
        captured = w;
      end
    end
  endtask

  task automatic period(input logic [WORD-1:0] wa, input logic [WORD-1:0] wb,
                        input logic s, input logic p);
    for (int i = 0; i < BITS; i++) step(i < 4 ? wa : wb, s, p);
  endtask

  task automatic period_var(input logic s);
    for (int i = 0; i < BITS; i++) step(WORD'($urandom), s, 1'b1);
  endtask

  initial begin
    #(200000 * 8);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pix_clk = 1'b0; frame_strobe = 1'b0;
    rise_sel = 1'b0; pd_n = 1'b1; pix_word = '0;
    // R9: reset state
    tag = "R9";
    period(28'hFFFFFFF, 28'hAAAAAAA, 1'b1, 1'b1);
    period(28'h5555555, 28'hFFFFFFF, 1'b1, 1'b1);
    @(negedge bit_clk);
    check_outputs();
    rst_n = 1'b1;
    period(28'h0F0F0F0, 28'h1234567, 1'b1, 1'b1);
    // R3: rising edge capture
    tag = "R3";
    for (int n = 0; n < 6; n++)
      period(WORD'($urandom), WORD'($urandom), 1'b1, 1'b1);
    // R4: falling edge capture, including the switch from rising
    tag = "R4";
    for (int n = 0; n < 6; n++)
      period(WORD'($urandom), WORD'($urandom), 1'b0, 1'b1);
    tag = "R3";
    period(28'hABCDEF1, 28'h7654321, 1'b1, 1'b1);
    period(28'h1111111, 28'h2222222, 1'b1, 1'b1);
    // R2: walking one across all bit positions
    tag = "R2";
    for (int b = 0; b < WORD; b++)
      period(WORD'(1) << b, ~(WORD'(1) << b), 1'b1, 1'b1);
    // R8: input changes every bit slot
    tag = "R8";
    for (int n = 0; n < 5; n++) period_var(1'b1);
    for (int n = 0; n < 5; n++) period_var(1'b0);
    // R5: power down and resume
    tag = "R5";
    for (int n = 0; n < 4; n++)
      period(28'hFFFFFFF, 28'hFFFFFFF, 1'b1, 1'b0);
    for (int n = 0; n < 3; n++)
      period(WORD'($urandom), WORD'($urandom), 1'b1, 1'b1);
    tag = "R1";
    period(28'h0000000, 28'hFFFFFFF, 1'b0, 1'b1);
    period(28'hFFFFFFF, 28'h0000000, 1'b0, 1'b1);
    period(28'h0000000, 28'h0000000, 1'b0, 1'b1);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule